// File: doc/BRIEF.md
# Four-Channel Pulse Trace Recorder

This block records short windows of complex (I/Q) signals around an RF pulse, much as a storage oscilloscope does. The sample stream carries I and Q interleaved on one time-shared lane, and every sample is flagged as I or Q. Five sources arrive in lockstep: forward wave, reflected wave, cavity field, drive output and a spare study signal. Each of four channels picks one of these sources. All four channels then fill their own buffer at the same moments, controlled by a shared trigger, start offset and decimation.

Software writes the source codes, the start offset (pan) and the decimation ratio (zoom), then pulses `arm`. Capture starts on the next rising edge of the RF gate. A configurable number of I/Q pairs is skipped first. After that, one pair is kept out of every `zoom` pairs until every buffer is full. At that point `done` is raised and the buffers stay frozen until the next arm.

Buffers are read through a request/response pair that uses valid/ready on both sides. A request is taken when `req_valid` and `req_ready` are both high. Its data appears with `resp_valid` on the following cycle and is held until the consumer raises `resp_ready`. `req_ready` is low only while an earlier response is still waiting, so read back-pressure goes back to the requester. The sample input is a free-running converter stream that cannot be stalled, so it has a valid strobe and no ready.

Top module: `trc_recorder`

## Requirements
- R1: After reset, `done` and `resp_valid` are 0, `req_ready` is 1, and no buffer is written until an arm is followed by a gate rising edge.
- R2: Each channel stores the source given by its 3-bit field in `sel_cfg` (channel c uses bits 3c+2..3c). The codes are 0 forward, 1 reflected, 2 cavity, 3 drive, and 4 study; codes 5 to 7 also select study. All four channels record in the same cycles.
- R3: Capture starts only on a 0-to-1 transition of `rf_gate` seen while armed. A gate edge with no arm pending has no effect. A sample presented in the same cycle as the edge is not counted.
- R4: After the edge, the first `pan` I samples (pan counted in I/Q pairs) and the Q samples that go with them are skipped. An isolated Q sample arriving before any I sample is not counted.
- R5: With zoom value Z (0 is treated as 1), pair number pan+k·Z after the edge is stored. Its I goes to address 2k and its Q to address 2k+1.
- R6: When address DEPTH-1 has been written, `done` goes to 1 and no further writes take place. The buffers and `done` stay unchanged, including across later gate edges, until an arm. An arm clears `done` on the next cycle.
- R7: Source codes, pan and zoom are captured when `arm` is pulsed. Changing them afterwards has no effect on a capture already in progress.
- R8: A read request accepted in cycle t returns buffer `req_ch` at `req_addr` with `resp_valid` high in cycle t+1. The response stays stable until `resp_ready` is high, and `req_ready` equals `!resp_valid || resp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_fwd | input | 16 | Forward-wave sample |
| src_rfl | input | 16 | Reflected-wave sample |
| src_cav | input | 16 | Cavity-field sample |
| src_drv | input | 16 | Drive-output sample |
| src_study | input | 16 | Study sample |
| src_valid | input | 1 | Sample strobe shared by all five sources |
| src_q | input | 1 | 1 when the current sample is Q, 0 when it is I |
| rf_gate | input | 1 | RF pulse gate; its rising edge is the trigger |
| arm | input | 1 | One-cycle pulse that latches the configuration and arms the recorder |
| sel_cfg | input | 12 | Four 3-bit source codes, channel 0 in the lowest bits |
| pan_cfg | input | 16 | Number of pairs to skip after the trigger |
| zoom_cfg | input | 8 | Decimation ratio in pairs |
| done | output | 1 | All buffers are full and frozen |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request can be accepted |
| req_ch | input | 2 | Channel to read |
| req_addr | input | 10 | Buffer address to read |
| resp_valid | output | 1 | Read data valid |
| resp_ready | input | 1 | Consumer takes read data |
| resp_data | output | 16 | Read data |

## Verification
The assertions check four things on every cycle. No write happens while `done` is high. `done` stays set until an arm, and an arm clears it. The latched configuration does not move during a run. A stalled response stays fixed. Only the bench scenarios can show the rest: that the right source reaches each buffer, that the pan offset and the decimation land on the right sample indices with I and Q at their proper addresses, that mid-run changes to the configuration and stray gate edges leave no trace, and that read data keeps its order under back-pressure. The bench confirms these by reading back all four buffers after captures that use different selections, pans and zooms.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_WAIT,
    ST_CAP,
    ST_DONE
  } trc_state_e;
endpackage

// File: rtl/trc_src_mux.sv
module trc_src_mux #(
  parameter int NSRC = 5,
  parameter int DW   = 16,
  parameter int SELW = 3
) (
  input  logic [NSRC*DW-1:0] srcs,
  input  logic [SELW-1:0]    sel,
  output logic [DW-1:0]      dout
);
  // codes past the last source fold onto the last (study) source
  always_comb begin
    dout = srcs[(NSRC-1)*DW +: DW];
    for (int s = 0; s < NSRC - 1; s++) begin
      if (int'(sel) == s) dout = srcs[s*DW +: DW];
    end
  end
endmodule

// File: rtl/trc_buf.sv
module trc_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/trc_capture_ctrl.sv
module trc_capture_ctrl
  import trc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SELW  = 3,
  parameter int DEPTH = 1024,
  parameter int DLYW  = 16,
  parameter int ZW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              rf_gate,
  input  logic              smp_valid,
  input  logic              smp_q,
  input  logic [NCH*SELW-1:0] sel_in,
  input  logic [DLYW-1:0]   pan_in,
  input  logic [ZW-1:0]     zoom_in,
  output logic [NCH*SELW-1:0] sel_r,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic              done
);
  localparam logic [PW-1:0] LAST_PAIR = PW'((DEPTH / 2) - 1);

  trc_state_e      st;
  logic            gate_q;
  logic [DLYW-1:0] skip;
  logic [ZW-1:0]   zoom_r;
  logic [ZW-1:0]   dcnt;
  logic [ZW-1:0]   zlim;
  logic [PW-1:0]   pair;
  logic            gate_edge;
  logic            start_now;

  assign gate_edge = rf_gate & ~gate_q;
  assign zlim      = (zoom_r == '0) ? '0 : zoom_r - 1'b1;
  assign start_now = (st == ST_WAIT) && smp_valid && !smp_q && (skip == '0);
  assign wr_en     = start_now || ((st == ST_CAP) && smp_valid && (dcnt == '0));
  assign wr_addr   = {pair, smp_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      gate_q <= 1'b0;
      skip   <= '0;
      zoom_r <= '0;
      sel_r  <= '0;
      dcnt   <= '0;
      pair   <= '0;
      done   <= 1'b0;
    end else begin
      gate_q <= rf_gate;
      if (arm) begin
        st     <= ST_ARMED;
        sel_r  <= sel_in;
        zoom_r <= zoom_in;
        skip   <= pan_in;
        dcnt   <= '0;
        pair   <= '0;
        done   <= 1'b0;
      end else begin
        unique case (st)
          ST_ARMED: if (gate_edge) st <= ST_WAIT;
          ST_WAIT: begin
            if (smp_valid && !smp_q) begin
              if (skip == '0) st <= ST_CAP;
              else            skip <= skip - 1'b1;
            end
          end
          ST_CAP: begin
            if (smp_valid && smp_q) begin
              if (dcnt == '0) begin
                if (pair == LAST_PAIR) begin
                  st   <= ST_DONE;
                  done <= 1'b1;
                end else begin
                  pair <= pair + 1'b1;
                end
              end
              dcnt <= (dcnt == zlim) ? '0 : dcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_NO_WRITE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done); // R6
  AST_ARM_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !done); // R6
  AST_CFG_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && st != ST_IDLE) |=> ($stable(zoom_r) && $stable(sel_r))); // R7
endmodule

// File: rtl/trc_recorder.sv
module trc_recorder #(
  parameter int NCH   = 4,
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  parameter int SELW  = 3,
  parameter int DLYW  = 16,
  parameter int ZW    = 8,
  localparam int NSRC = 5,
  localparam int AW   = $clog2(DEPTH),
  localparam int CHW  = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DW-1:0]       src_fwd,
  input  logic [DW-1:0]       src_rfl,
  input  logic [DW-1:0]       src_cav,
  input  logic [DW-1:0]       src_drv,
  input  logic [DW-1:0]       src_study,
  input  logic                src_valid,
  input  logic                src_q,
  input  logic                rf_gate,
  input  logic                arm,
  input  logic [NCH*SELW-1:0] sel_cfg,
  input  logic [DLYW-1:0]     pan_cfg,
  input  logic [ZW-1:0]       zoom_cfg,
  output logic                done,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [CHW-1:0]      req_ch,
  input  logic [AW-1:0]       req_addr,
  output logic                resp_valid,
  input  logic                resp_ready,
  output logic [DW-1:0]       resp_data
);
  logic [NSRC*DW-1:0] srcs;
  logic [NCH*SELW-1:0] sel_r;
  logic               wr_en;
  logic [AW-1:0]      wr_addr;
  logic [DW-1:0]      ch_din  [NCH];
  logic [DW-1:0]      ch_dout [NCH];
  logic               rd_take;
  logic [CHW-1:0]     ch_r;

  assign srcs = {src_study, src_drv, src_cav, src_rfl, src_fwd};

  trc_capture_ctrl #(
    .NCH(NCH), .SELW(SELW), .DEPTH(DEPTH), .DLYW(DLYW), .ZW(ZW)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .rf_gate(rf_gate),
    .smp_valid(src_valid), .smp_q(src_q),
    .sel_in(sel_cfg), .pan_in(pan_cfg), .zoom_in(zoom_cfg),
    .sel_r(sel_r), .wr_en(wr_en), .wr_addr(wr_addr), .done(done)
  );

  assign req_ready = !resp_valid || resp_ready;
  assign rd_take   = req_valid && req_ready;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    trc_src_mux #(.NSRC(NSRC), .DW(DW), .SELW(SELW)) mux_i (
      .srcs(srcs), .sel(sel_r[c*SELW +: SELW]), .dout(ch_din[c])
    );
    trc_buf #(.DW(DW), .DEPTH(DEPTH)) buf_i (
      .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(ch_din[c]),
      .re(rd_take), .raddr(req_addr), .rdata(ch_dout[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      ch_r       <= '0;
    end else begin
      if (rd_take) begin
        resp_valid <= 1'b1;
        ch_r       <= req_ch;
      end else if (resp_ready) begin
        resp_valid <= 1'b0;
      end
    end
  end

  assign resp_data = ch_dout[ch_r];

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data))); // R8
  AST_REQ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |-> !req_ready); // R8
endmodule

// File: tb/trc_recorder_tb_top.sv
module trc_recorder_tb_top;
  localparam int NCH = 4, DW = 16, DEPTH = 1024, SELW = 3, DLYW = 16, ZW = 8;
  localparam int AW = 10, CHW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [DW-1:0] src_fwd = '0, src_rfl = '0, src_cav = '0, src_drv = '0, src_study = '0;
  logic src_valid = 1'b0, src_q = 1'b0, rf_gate = 1'b0, arm = 1'b0;
  logic [NCH*SELW-1:0] sel_cfg = '0;
  logic [DLYW-1:0] pan_cfg = '0;
  logic [ZW-1:0] zoom_cfg = '0;
  logic done, req_ready, resp_valid;
  logic req_valid = 1'b0, resp_ready = 1'b1;
  logic [CHW-1:0] req_ch = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] resp_data;

  trc_recorder dut_i (
    .clk(clk), .rst_n(rst_n), .src_fwd(src_fwd), .src_rfl(src_rfl),
    .src_cav(src_cav), .src_drv(src_drv), .src_study(src_study),
    .src_valid(src_valid), .src_q(src_q), .rf_gate(rf_gate), .arm(arm),
    .sel_cfg(sel_cfg), .pan_cfg(pan_cfg), .zoom_cfg(zoom_cfg), .done(done),
    .req_valid(req_valid), .req_ready(req_ready), .req_ch(req_ch),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data)
  );

  int errs = 0, checks = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // sample stream: value = {source index, running sample index}
  int cyc = 0, sidx = 0, first_i = 0;
  bit look = 0, up_req = 0, dn_req = 0;
  always @(negedge clk) begin
    bit v;
    cyc++;
    v = (cyc % 3) != 2;
    src_valid = v;
    if (v) begin
      src_q     = sidx[0];
      src_fwd   = {3'd0, 13'(sidx)};
      src_rfl   = {3'd1, 13'(sidx)};
      src_cav   = {3'd2, 13'(sidx)};
      src_drv   = {3'd3, 13'(sidx)};
      src_study = {3'd4, 13'(sidx)};
      if (look && !sidx[0]) begin
        first_i = sidx;
        look = 0;
      end
      sidx++;
    end
    if (up_req) begin
      rf_gate = 1'b1;
      up_req = 0;
      look = 1;
    end else if (dn_req) begin
      rf_gate = 1'b0;
      dn_req = 0;
    end
  end

  // monitor / scoreboard
  int rdy_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && resp_valid && resp_ready) begin
      if (exp_q.size() == 0) chk(0, "R8 unexpected response", resp_data, 0);
      else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(resp_data == e, t, resp_data, e);
      end
    end
    rdy_cnt++;
    resp_ready = (rdy_cnt % 4) != 3;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R6 watchdog expired", 0, 1);
    finish_run();
  end

  function automatic logic [DW-1:0] exp_val(int code, int k, int fi, int pan, int z);
    int src, n;
    src = (code > 4) ? 4 : code;
    n = fi + 2 * (pan + (k / 2) * z) + (k % 2);
    return {3'(src), 13'(n)};
  endfunction

  task automatic gate_pulse(input int len);
    up_req = 1;
    repeat (len) @(negedge clk);
    dn_req = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_arm(input logic [NCH*SELW-1:0] s, input int pan, input int z);
    @(negedge clk);
    sel_cfg = s; pan_cfg = DLYW'(pan); zoom_cfg = ZW'(z); arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R6 done after buffers fill", done, 1);
  endtask

  task automatic read_all(input logic [NCH*SELW-1:0] s, input int fi, input int pan,
                          input int z, input string tag);
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < DEPTH; k++) begin
        @(negedge clk);
        req_valid = 1'b1; req_ch = CHW'(c); req_addr = AW'(k);
        exp_q.push_back(exp_val(int'(s[c*SELW +: SELW]), k, fi, pan, z));
        tag_q.push_back($sformatf("%s ch%0d addr%0d", tag, c, k));
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    int fi;
    logic [NCH*SELW-1:0] s;
    repeat (5) @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(resp_valid == 1'b0, "R1 resp_valid after reset", resp_valid, 0);
    chk(req_ready == 1'b1, "R1 R8 req_ready after reset", req_ready, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // gate edge with no arm
    gate_pulse(20);
    repeat (50) @(negedge clk);
    chk(done == 1'b0, "R3 unarmed gate edge ignored", done, 0);

    // A: direct sources, no pan, no decimation
    s = {3'd3, 3'd2, 3'd1, 3'd0};
    do_arm(s, 0, 1);
    repeat (5) @(negedge clk);
    gate_pulse(30);
    chk(done == 1'b0, "R3 not done shortly after trigger", done, 0);
    wait_done();
    fi = first_i;
    read_all(s, fi, 0, 1, "R2 R3 R5 capture A");

    // B: pan and zoom, config disturbed mid-run, stray gate after done
    s = {3'd4, 3'd0, 3'd3, 3'd1};
    do_arm(s, 5, 3);
    chk(done == 1'b0, "R6 arm clears done", done, 0);
    repeat (4) @(negedge clk);
    gate_pulse(40);
    sel_cfg = {4{3'd2}}; zoom_cfg = 8'd7; pan_cfg = 16'd100;
    wait_done();
    fi = first_i;
    repeat (100) @(negedge clk);
    gate_pulse(25);
    repeat (100) @(negedge clk);
    chk(done == 1'b1, "R6 done holds across gate edge", done, 1);
    read_all(s, fi, 5, 3, "R4 R5 R6 R7 capture B");

    // C: zoom 0 treated as 1, high codes map to study
    s = {3'd7, 3'd5, 3'd2, 3'd4};
    do_arm(s, 2, 0);
    repeat (3) @(negedge clk);
    gate_pulse(10);
    wait_done();
    fi = first_i;
    read_all(s, fi, 2, 1, "R2 R4 R5 capture C");

    chk(exp_q.size() == 0, "R8 all responses returned", exp_q.size(), 0);
    finish_run();
  end
endmodule